// File: doc/BRIEF.md
# Conditional Window Sequencer for a 16-bit Instruction Stream

This block follows a stream of 16-bit instruction halfwords, one per cycle under a valid strobe, and watches for a predicating prefix opcode. A legal prefix opens a window of one to four following instructions. Each instruction in the window carries its own 4-bit condition code: either the base condition taken from the prefix, or the base with its lowest bit flipped. The block also receives the live NZCV flags and reports whether the condition for the presented instruction holds.

The block also checks the prefix encodings. It reports reserved hint forms and unpredictable forms. Inside a window, it tells the downstream decoder when a flag-setting data-processing instruction must leave the flags untouched. All indications describe the halfword presented in the same cycle. The window state moves forward on the clock edge that accepts each valid halfword. A synchronous clear input aborts a window, for example on a pipeline flush.

Top module: `cond_window_seq`

## Requirements
- R1: Out of reset no window is open: `win_active` is 0, `slot_cond` reads 1110, `cond_pass` is 1, and `start_block`, `hint_seen`, `prefix_bad` and `keep_flags` are all 0 while no valid halfword is presented.
- R2: A valid halfword with bits [15:8] = 1011_1111, a nonzero low nibble (mask) and a legal condition in bits [7:4], presented while no window is open and without clear, raises `start_block` in that cycle. From the next cycle `win_active` is 1 and `slot_cond` equals bits [7:4].
- R3: The window length is set by the lowest set mask bit: bit 3 gives 1 instruction, bit 2 gives 2, bit 1 gives 3 and bit 0 gives 4. Each valid halfword inside the window uses one slot, and the window closes after the last one.
- R4: Instruction n of the window (n = 2..4) has the condition {base[3:1], mask[5-n]}. A mask bit equal to base[0] therefore keeps the base condition, and a differing bit inverts its least significant bit.
- R5: A prefix halfword with mask 0000 is a hint. It raises `hint_seen`, never raises `start_block`, and inside a window it uses one slot like any other instruction.
- R6: A prefix with condition 1111 raises `prefix_bad` and opens no window.
- R7: A prefix with condition 1110 raises `prefix_bad` and opens no window unless exactly one mask bit is set.
- R8: A non-hint prefix presented while a window is open raises `prefix_bad`, does not reload the window, and uses one slot.
- R9: `cond_pass` gives the condition result for `slot_cond` against NZCV (N=bit 3, Z=2, C=1, V=0): 0 EQ Z, 1 NE !Z, 2 CS C, 3 CC !C, 4 MI N, 5 PL !N, 6 VS V, 7 VC !V, 8 HI C&!Z, 9 LS !(C&!Z), A GE N==V, B LT N!=V, C GT !Z&(N==V), D LE its inverse, E and F always 1.
- R10: `keep_flags` is 1 for a valid halfword inside a window unless it belongs to the compare class: 00101xxxxxxxxxxx, 0100001000xxxxxx, 0100001010xxxxxx, 0100001011xxxxxx, 01000101xxxxxxxx.
- R11: `flush` closes any window at the next edge. It also blocks a prefix presented in the same cycle, so `start_block` stays 0.
- R12: Cycles without `in_valid` leave the window state and `slot_cond` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous abort of any open window |
| in_valid | input | 1 | A halfword is presented this cycle |
| in_hw | input | 16 | Presented instruction halfword |
| nzcv | input | 4 | Current condition flags N,Z,C,V |
| win_active | output | 1 | Presented instruction lies inside a window |
| slot_cond | output | 4 | Condition applying to the presented instruction (1110 outside) |
| cond_pass | output | 1 | `slot_cond` holds for `nzcv` |
| start_block | output | 1 | Legal prefix accepted this cycle |
| hint_seen | output | 1 | Prefix pattern with zero mask |
| prefix_bad | output | 1 | Unpredictable prefix |
| keep_flags | output | 1 | Downstream must suppress flag update |

## Verification
Every output is combinational in the halfword, flags and clear of the current cycle, together with the state stored at the previous edge. Indications such as `start_block`, `prefix_bad`, `hint_seen` and `keep_flags` are therefore due in the same cycle as their stimulus. Window consequences, such as a new base condition, the next slot's condition or a closed window, appear one edge later. The bench drives inputs on the falling edge and compares all outputs halfway through the low phase against a queue-based model of the pending slot conditions. It moves that model forward only after the compare, which matches the one-edge latency of the window state.

// File: rtl/cond_window_pkg.sv
package cond_window_pkg;

    localparam int HW_W     = 16;
    localparam int COND_W   = 4;
    localparam int MASK_W   = 4;
    localparam int TAG_W    = HW_W - COND_W - MASK_W;
    localparam logic [TAG_W-1:0]  PREFIX_TAG = 8'hBF;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;
    localparam logic [COND_W-1:0] COND_NEVER  = 4'hF;

    // compare-class patterns: halfword & care == val
    localparam int CMP_N = 5;
    localparam logic [HW_W-1:0] CMP_CARE [CMP_N] =
        '{16'hF800, 16'hFFC0, 16'hFFC0, 16'hFFC0, 16'hFF00};
    localparam logic [HW_W-1:0] CMP_VAL  [CMP_N] =
        '{16'h2800, 16'h4200, 16'h4280, 16'h42C0, 16'h4500};

    typedef struct packed {
        logic                is_prefix;
        logic [COND_W-1:0]   base;
        logic [MASK_W-1:0]   mask;
    } prefix_fields_t;

    typedef struct packed {
        logic start;
        logic hint;
        logic bad;
    } prefix_verdict_t;

    function automatic logic cond_holds(input logic [COND_W-1:0] c,
                                        input logic [3:0] f);
        logic n, z, cy, v, r;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c[3:1])
            3'd0:    r = z;
            3'd1:    r = cy;
            3'd2:    r = n;
            3'd3:    r = v;
            3'd4:    r = cy & ~z;
            3'd5:    r = (n == v);
            3'd6:    r = ~z & (n == v);
            default: r = 1'b1;
        endcase
        if (c[3:1] != 3'd7) r = r ^ c[0];
        return r;
    endfunction

endpackage

// File: rtl/cwin_prefix_dec.sv
module cwin_prefix_dec
    import cond_window_pkg::*;
(
    input  logic                in_valid,
    input  logic [HW_W-1:0]     in_hw,
    input  logic                flush,
    input  logic                active,
    output prefix_fields_t      fields,
    output prefix_verdict_t     verdict
);
    logic one_hot_mask;
    logic cond_illegal;

    always_comb begin
        fields.is_prefix = in_valid && (in_hw[HW_W-1 -: TAG_W] == PREFIX_TAG);
        fields.base      = in_hw[COND_W+MASK_W-1 -: COND_W];
        fields.mask      = in_hw[MASK_W-1:0];

        one_hot_mask = ($countones(fields.mask) == 1);
        cond_illegal = (fields.base == COND_NEVER) ||
                       ((fields.base == COND_ALWAYS) && !one_hot_mask);

        verdict.hint  = fields.is_prefix && (fields.mask == '0);
        verdict.bad   = fields.is_prefix && (fields.mask != '0) &&
                        (cond_illegal || active);
        verdict.start = fields.is_prefix && (fields.mask != '0) &&
                        !cond_illegal && !active && !flush;
    end
endmodule

// File: rtl/cwin_state.sv
module cwin_state
    import cond_window_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                in_valid,
    input  logic                start,
    input  prefix_fields_t      fields,
    output logic                active,
    output logic [COND_W-1:0]   cur_cond
);
    logic [COND_W-1:0] cond_q;
    logic [MASK_W-1:0] mask_q;

    assign active   = (mask_q != '0);
    assign cur_cond = active ? cond_q : COND_ALWAYS;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= COND_ALWAYS;
            mask_q <= '0;
        end else if (flush) begin
            mask_q <= '0;
        end else if (in_valid) begin
            if (start) begin
                cond_q <= fields.base;
                mask_q <= fields.mask;
            end else if (active) begin
                cond_q[0] <= mask_q[MASK_W-1];
                mask_q    <= {mask_q[MASK_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/cwin_flag_filter.sv
module cwin_flag_filter
    import cond_window_pkg::*;
(
    input  logic            in_valid,
    input  logic            active,
    input  logic [HW_W-1:0] in_hw,
    output logic            keep_flags
);
    logic [CMP_N-1:0] hit;

    for (genvar i = 0; i < CMP_N; i++) begin : g_cmp
        assign hit[i] = ((in_hw & CMP_CARE[i]) == CMP_VAL[i]);
    end

    assign keep_flags = in_valid && active && (hit == '0);
endmodule

// File: rtl/cond_window_seq.sv
module cond_window_seq
    import cond_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [15:0]       in_hw,
    input  logic [3:0]        nzcv,
    output logic              win_active,
    output logic [3:0]        slot_cond,
    output logic              cond_pass,
    output logic              start_block,
    output logic              hint_seen,
    output logic              prefix_bad,
    output logic              keep_flags
);
    prefix_fields_t  fields;
    prefix_verdict_t verdict;
    logic            active;
    logic [COND_W-1:0] cur_cond;

    cwin_prefix_dec u_dec (
        .in_valid (in_valid),
        .in_hw    (in_hw),
        .flush    (flush),
        .active   (active),
        .fields   (fields),
        .verdict  (verdict)
    );

    cwin_state u_state (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .in_valid (in_valid),
        .start    (verdict.start),
        .fields   (fields),
        .active   (active),
        .cur_cond (cur_cond)
    );

    cwin_flag_filter u_filt (
        .in_valid   (in_valid),
        .active     (active),
        .in_hw      (in_hw),
        .keep_flags (keep_flags)
    );

    assign win_active  = active;
    assign slot_cond   = cur_cond;
    assign cond_pass   = cond_holds(cur_cond, nzcv);
    assign start_block = verdict.start;
    assign hint_seen   = verdict.hint;
    assign prefix_bad  = verdict.bad;
endmodule

// File: rtl/cond_window_chk.sv
module cond_window_chk (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        in_valid,
    input logic [15:0] in_hw,
    input logic [3:0]  nzcv,
    input logic        win_active,
    input logic [3:0]  slot_cond,
    input logic        cond_pass,
    input logic        start_block,
    input logic        hint_seen,
    input logic        prefix_bad,
    input logic        keep_flags
);
    p_start_loads_r2: assert property (@(posedge clk) disable iff (rst)
        start_block |=> win_active && slot_cond == $past(in_hw[7:4]));

    p_hint_no_start_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_hw[15:8] == 8'hBF && in_hw[3:0] == 4'h0)
            |-> hint_seen && !start_block);

    p_never_cond_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_hw[15:4] == 12'hBFF && in_hw[3:0] != 4'h0)
            |-> prefix_bad && !start_block);

    p_nested_bad_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && win_active && in_hw[15:8] == 8'hBF && in_hw[3:0] != 4'h0)
            |-> prefix_bad && !start_block);

    p_always_passes_r9: assert property (@(posedge clk) disable iff (rst)
        (slot_cond == 4'hE) |-> cond_pass);

    p_keep_in_window_r10: assert property (@(posedge clk) disable iff (rst)
        keep_flags |-> win_active && in_valid);

    p_flush_closes_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> !win_active);

    p_idle_holds_r12: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !flush) |=> $stable(slot_cond) && $stable(win_active));
endmodule

bind cond_window_seq cond_window_chk u_chk (.*);

// File: tb/cond_window_seq_tb.sv
module cond_window_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_hw = 16'h0;
    logic [3:0]  nzcv = 4'h0;
    logic        win_active, cond_pass, start_block, hint_seen, prefix_bad, keep_flags;
    logic [3:0]  slot_cond;

    int checks = 0;
    int fails  = 0;
    int q[$];
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    cond_window_seq u_dut (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_hw(in_hw),
        .nzcv(nzcv), .win_active(win_active), .slot_cond(slot_cond),
        .cond_pass(cond_pass), .start_block(start_block), .hint_seen(hint_seen),
        .prefix_bad(prefix_bad), .keep_flags(keep_flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit ref_pass(input int c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;            1: return !z;
            2: return cy;           3: return !cy;
            4: return n;            5: return !n;
            6: return v;            7: return !v;
            8: return cy && !z;     9: return !(cy && !z);
            10: return n == v;      11: return n != v;
            12: return !z && n == v; 13: return !(!z && n == v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit ref_cmp(input logic [15:0] h);
        if (h[15:11] == 5'b00101) return 1'b1;
        if (h[15:8] == 8'b0100_0101) return 1'b1;
        if (h[15:10] == 6'b010000 && h[9:8] == 2'b10 && h[7:6] != 2'b01) return 1'b1;
        return 1'b0;
    endfunction

    // R1..R12: every cycle is compared against the slot-queue model
    task automatic step(input bit v, input logic [15:0] h, input logic [3:0] f, input bit fl);
        bit act, pre, hint_e, bad_e, start_e, keep_e;
        int ce, pf, pm, low;
        @(negedge clk);
        in_valid = v; in_hw = h; nzcv = f; flush = fl;
        #5;
        act = (q.size() > 0);
        pre = v && (h[15:8] == 8'hBF);
        pf = h[7:4]; pm = h[3:0];
        hint_e  = pre && pm == 0;
        bad_e   = pre && pm != 0 && (pf == 15 || (pf == 14 && $countones(h[3:0]) != 1) || act);
        start_e = pre && pm != 0 && !bad_e && !fl;
        keep_e  = v && act && !ref_cmp(h);
        ce = act ? q[0] : 14;
        chk("R3 win_active", int'(win_active), int'(act));
        chk("R4 slot_cond", int'(slot_cond), ce);
        chk("R9 cond_pass", int'(cond_pass), int'(ref_pass(ce, f)));
        chk("R2 start_block", int'(start_block), int'(start_e));
        chk("R5 hint_seen", int'(hint_seen), int'(hint_e));
        chk(pf == 15 ? "R6 prefix_bad" : (act ? "R8 prefix_bad" : "R7 prefix_bad"),
            int'(prefix_bad), int'(bad_e));
        chk("R10 keep_flags", int'(keep_flags), int'(keep_e));
        if (fl) q.delete();
        else if (v) begin
            if (start_e) begin
                low = 0;
                while (!h[low]) low++;
                q.push_back(pf);
                for (int b = 3; b > low; b--) q.push_back((pf & 14) | int'(h[b]));
            end else if (act) begin
                void'(q.pop_front());
            end
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #5;
        // R1 reset state
        chk("R1 win_active", int'(win_active), 0);
        chk("R1 slot_cond", int'(slot_cond), 14);
        chk("R1 cond_pass", int'(cond_pass), 1);
        chk("R1 indications", int'({start_block, hint_seen, prefix_bad, keep_flags}), 0);

        // R2/R3 single slot EQ, then flag-setting add inside
        step(1, 16'hBF08, 4'h0, 0);
        step(1, 16'h1840, 4'h4, 0);
        step(1, 16'h1840, 4'h4, 0);
        // R4 four slots, all else
        step(1, 16'hBF11, 4'h0, 0);
        for (int i = 0; i < 4; i++) step(1, 16'h1840, 4'(i * 5), 0);
        step(1, 16'h0000, 4'h0, 0);
        // R4 three slots mixed
        step(1, 16'hBF0A, 4'h0, 0);
        step(1, 16'h2805, 4'h4, 0);
        step(1, 16'h4288, 4'h0, 0);
        step(1, 16'h4208, 4'h4, 0);
        // R5 hints outside and inside
        step(1, 16'hBF00, 4'h0, 0);
        step(1, 16'hBF10, 4'h0, 0);
        step(1, 16'hBF84, 4'h2, 0);
        step(1, 16'hBF30, 4'h2, 0);
        step(1, 16'h42C8, 4'h2, 0);
        // R6 and R7
        step(1, 16'hBFF8, 4'h0, 0);
        step(1, 16'hBFEC, 4'h0, 0);
        step(1, 16'hBFE8, 4'h0, 0);
        step(1, 16'h4548, 4'h0, 0);
        // R8 nested prefix uses a slot
        step(1, 16'hBFA2, 4'h9, 0);
        step(1, 16'hBF18, 4'h9, 0);
        step(1, 16'h1840, 4'h1, 0);
        step(1, 16'h1840, 4'h1, 0);
        // R12 gaps inside window
        step(1, 16'hBFC1, 4'h0, 0);
        step(0, 16'h1840, 4'h0, 0);
        step(0, 16'hBF08, 4'h0, 0);
        chk("R12 window held", int'(win_active), 1);
        step(1, 16'h1840, 4'h8, 0);
        // R11 flush mid window and with prefix
        step(1, 16'h1840, 4'h0, 1);
        #1 chk("R11 start blocked by flush", int'(start_block), 0);
        step(1, 16'hBF48, 4'h0, 1);
        chk("R11 start blocked with prefix", int'(start_block), 0);
        step(0, 16'h0000, 4'h0, 0);
        chk("R11 window closed", int'(win_active), 0);

        // mixed stream
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] h;
            rng = nxt(rng);
            h = rng[15:0];
            if (rng[18:17] == 2'b00) h[15:8] = 8'hBF;
            else if (rng[18:17] == 2'b01) h[15:8] = {4'h4, 2'b00, rng[20:19]};
            step(rng[21:20] != 2'b00, h, rng[25:22], rng[31:27] == 5'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule